// File: doc/BRIEF.md
# Second-Order Sinc Decimator with Peak Tracking

This block is the digital back end of a single-bit oversampling voice converter. It accepts a one-bit stream, one bit per cycle of the oversampled clock. A second-order sinc (cascaded integrator-comb) filter reduces the rate by 256. The integrators run on every cycle. The two differencing stages run only on the cycle picked by an internal modulo-256 phase counter, which acts as a clock enable, so the whole block stays in a single clock domain. Each decimated result is presented as a signed 16-bit word. Input bit 1 counts as one and bit 0 as zero, and a fixed mid-scale offset turns the unsigned filter sum into two's complement.

A running minimum and maximum of the settled output words is also kept. A 12-bit hold-off count is captured while reset is asserted. Tracking stays suspended for that many settled samples, so the start-up transient of the analog front end does not reach the peak registers. The first sample after the hold-off seeds both peak registers.

Top module: `sinc_decimator`

## Requirements
- R1: After reset is released, let the clock edges be numbered t = 1, 2, ... and let x[t] be the bit present at edge t (x = 0 before t = 1). At each edge T = 256k (k >= 1) `sample` takes the value y - 32768, where y is the sum over j of w(j)·x[j] with w(j) = min(j+255, T-2) - max(j, T-257) + 1 where this is positive. Between those edges `sample` holds.
- R2: Full scale is clipped. When y = 65536 (a long run of ones), `sample` is 32767 (0x7FFF). A long run of zeros gives -32768 (0x8000).
- R3: `sampleValid` is high for exactly the one cycle after each edge T = 256k with k >= 3. The first two decimated words are filter warm-up and are never flagged.
- R4: The integrators wrap modulo 2^17, so the outputs stay exact for any length of input, including unbroken runs of ones.
- R5: The first N flagged samples after reset leave `peakMin` and `peakMax` unchanged, where N is the value of `waitPeriod` during reset. Words produced during warm-up never touch them either.
- R6: The first flagged sample after the hold-off sets both `peakMin` and `peakMax` to that sample.
- R7: Each later flagged sample lowers `peakMin` or raises `peakMax` when it lies outside the range [`peakMin`, `peakMax`]. The comparison is signed.
- R8: A change of `waitPeriod` while reset is low has no effect on peak tracking.
- R9: While reset is asserted, `sample`, `sampleValid`, `peakMin` and `peakMax` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled clock |
| rst | input | 1 | Synchronous reset, active high |
| bitIn | input | 1 | Modulator bitstream, one bit per clock |
| waitPeriod | input | 12 | Peak hold-off count in settled samples, captured during reset |
| sample | output | 16 | Decimated signed output word |
| sampleValid | output | 1 | One-cycle flag marking a new settled word |
| peakMin | output | 16 | Smallest settled word tracked so far |
| peakMax | output | 16 | Largest settled word tracked so far |

## Verification
A corrupted integrator or comb delay does not stay hidden. It shifts `sample` away from the triangular-weighted sum at the next decimation edge, at most 256 cycles later, and keeps it wrong for the next two words. A phase or warm-up counter that slips moves or adds a `sampleValid` pulse, and the cycle-exact comparison catches it at once. A wrong hold-off count or seeding shows up in `peakMin` or `peakMax` at the first flagged sample after the expected seeding point. Because the stimulus includes full-scale blocks, the extreme values and the clipping are exercised in every run.

// File: rtl/sincdec_pkg.sv
package sincdec_pkg;

  // Strobes issued by the control unit to the datapath, one clock wide each.
  typedef struct packed {
    logic decimate;   // comb stages advance, output word refreshed
    logic settled;    // this output word is past filter warm-up
    logic track;      // this output word feeds the peak registers
    logic seedPeak;   // first tracked word: load both peak registers
  } ctrlStrobe_t;

endpackage

// File: rtl/sincdec_ctrl.sv
module sincdec_ctrl
  import sincdec_pkg::*;
#(
  parameter int DECIM_LOG2 = 8,
  parameter int ORDER      = 2,
  parameter int WAIT_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WAIT_W-1:0] waitPeriod,
  output ctrlStrobe_t       strobes
);

  localparam int WARM_W = $clog2(ORDER + 1);

  logic [DECIM_LOG2-1:0] phaseCnt;
  logic [WARM_W-1:0]     warmCnt;
  logic [WAIT_W-1:0]     waitCnt;
  logic                  peakLive;
  logic                  warmDone;

  assign warmDone          = (warmCnt == WARM_W'(ORDER));
  assign strobes.decimate  = &phaseCnt;
  assign strobes.settled   = strobes.decimate && warmDone;
  assign strobes.track     = strobes.settled && (waitCnt == '0);
  assign strobes.seedPeak  = strobes.track && !peakLive;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt <= '0;
      warmCnt  <= '0;
      waitCnt  <= waitPeriod;   // hold-off captured only here (R8)
      peakLive <= 1'b0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
      if (strobes.decimate && !warmDone) warmCnt <= warmCnt + 1'b1;
      if (strobes.settled && (waitCnt != '0)) waitCnt <= waitCnt - 1'b1;
      if (strobes.track) peakLive <= 1'b1;
    end
  end

  // The decimation strobe is never two cycles in a row.
  AST_DECIM_SPACED: assert property (@(posedge clk) disable iff (rst)
    strobes.decimate |=> !strobes.decimate);   // R3

  // Once seeded, the peak registers are never seeded again.
  AST_SEED_ONCE: assert property (@(posedge clk) disable iff (rst)
    strobes.seedPeak |=> !strobes.seedPeak && peakLive);   // R6

endmodule

// File: rtl/sincdec_path.sv
module sincdec_path
  import sincdec_pkg::*;
#(
  parameter int DECIM_LOG2 = 8,
  parameter int ORDER      = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bitIn,
  input  ctrlStrobe_t                   strobes,
  output logic [ORDER*DECIM_LOG2-1:0]   sample,
  output logic                          sampleValid,
  output logic [ORDER*DECIM_LOG2-1:0]   peakMin,
  output logic [ORDER*DECIM_LOG2-1:0]   peakMax
);

  localparam int OUT_W = ORDER * DECIM_LOG2;
  localparam int ACC_W = OUT_W + 1;   // holds 0 .. 2^OUT_W exactly

  logic [ACC_W-1:0] integ   [ORDER];
  logic [ACC_W-1:0] dly     [ORDER];
  logic [ACC_W-1:0] combTap [ORDER+1];
  logic [ACC_W-1:0] yFull;
  logic [OUT_W-1:0] sampleNext;
  logic             peakSeen;

  // Integrator chain, wraparound arithmetic at the oversampled rate.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ORDER; i++) integ[i] <= '0;
    end else begin
      integ[0] <= integ[0] + {{(ACC_W-1){1'b0}}, bitIn};
      for (int i = 1; i < ORDER; i++) integ[i] <= integ[i] + integ[i-1];
    end
  end

  // Comb chain, evaluated combinationally, registered on the decimation strobe.
  always_comb begin
    combTap[0] = integ[ORDER-1];
    for (int i = 0; i < ORDER; i++) combTap[i+1] = combTap[i] - dly[i];
  end

  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    always_ff @(posedge clk) begin
      if (rst)                   dly[g] <= '0;
      else if (strobes.decimate) dly[g] <= combTap[g];
    end
  end

  // Offset to two's complement; the single overrange code clips to +max.
  assign yFull      = combTap[ORDER];
  assign sampleNext = yFull[OUT_W] ? {1'b0, {(OUT_W-1){1'b1}}}
                                   : {~yFull[OUT_W-1], yFull[OUT_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sample      <= '0;
      sampleValid <= 1'b0;
      peakMin     <= '0;
      peakMax     <= '0;
      peakSeen    <= 1'b0;
    end else begin
      sampleValid <= strobes.settled;
      if (strobes.decimate) sample <= sampleNext;
      if (strobes.track) begin
        peakSeen <= 1'b1;
        if (strobes.seedPeak) begin
          peakMin <= sampleNext;
          peakMax <= sampleNext;
        end else begin
          if ($signed(sampleNext) < $signed(peakMin)) peakMin <= sampleNext;
          if ($signed(sampleNext) > $signed(peakMax)) peakMax <= sampleNext;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);   // R3

  AST_VALID_AFTER_DECIM: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> $past(strobes.decimate));   // R3

  AST_PEAK_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !strobes.track |=> $stable(peakMin) && $stable(peakMax));   // R5

  AST_SEED_EQUAL: assert property (@(posedge clk) disable iff (rst)
    strobes.seedPeak |=> (peakMin == peakMax) && (peakMin == sample));   // R6

  AST_PEAK_ORDER: assert property (@(posedge clk) disable iff (rst)
    peakSeen |-> ($signed(peakMin) <= $signed(peakMax)));   // R7

endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import sincdec_pkg::*;
#(
  parameter int DECIM_LOG2 = 8,
  parameter int ORDER      = 2,
  parameter int WAIT_W     = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bitIn,
  input  logic [WAIT_W-1:0]           waitPeriod,
  output logic [ORDER*DECIM_LOG2-1:0] sample,
  output logic                        sampleValid,
  output logic [ORDER*DECIM_LOG2-1:0] peakMin,
  output logic [ORDER*DECIM_LOG2-1:0] peakMax
);

  ctrlStrobe_t strobes;

  sincdec_ctrl #(
    .DECIM_LOG2(DECIM_LOG2), .ORDER(ORDER), .WAIT_W(WAIT_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .waitPeriod(waitPeriod), .strobes(strobes)
  );

  sincdec_path #(
    .DECIM_LOG2(DECIM_LOG2), .ORDER(ORDER)
  ) i_path (
    .clk(clk), .rst(rst), .bitIn(bitIn), .strobes(strobes),
    .sample(sample), .sampleValid(sampleValid),
    .peakMin(peakMin), .peakMax(peakMax)
  );

endmodule

// File: tb/test_sinc_decimator.sv
`timescale 1ns/1ps
module test_sinc_decimator;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bitIn = 1'b0;
  logic [11:0] waitPeriod = '0;
  logic [15:0] sample, peakMin, peakMax;
  logic        sampleValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  bit hist [1024];

  always #2.5 clk = ~clk;

  sinc_decimator i_sinc_decimator (
    .clk(clk), .rst(rst), .bitIn(bitIn), .waitPeriod(waitPeriod),
    .sample(sample), .sampleValid(sampleValid),
    .peakMin(peakMin), .peakMax(peakMax)
  );

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // R1: triangular-weighted sum of the bits ending at edge T.
  function automatic int expY(input int T);
    int y = 0;
    for (int j = T - 512; j <= T - 2; j++) begin
      if (j >= 1) begin
        int lo = (j > T - 257) ? j : T - 257;
        int hi = (j + 255 < T - 2) ? j + 255 : T - 2;
        if (hi >= lo) y += (hi - lo + 1) * int'(hist[j % 1024]);
      end
    end
    return y;
  endfunction

  // R2: offset and clip to signed 16 bits.
  function automatic int toSample(input int y);
    return (y >= 65536) ? 32767 : y - 32768;
  endfunction

  task automatic doRun(input int waitVal, input int nOut);
    int expSample = 0, expMin = 0, expMax = 0, waitLeft = waitVal;
    int dens = 50;
    bit seeded = 0;
    for (int i = 0; i < 1024; i++) hist[i] = 0;
    rst = 1'b1;
    bitIn = 1'b0;
    waitPeriod = 12'(waitVal);
    repeat (3) @(negedge clk);
    chk("R9 sample", int'($signed(sample)), 0);
    chk("R9 valid", int'(sampleValid), 0);
    chk("R9 min", int'($signed(peakMin)), 0);
    chk("R9 max", int'($signed(peakMax)), 0);
    rst = 1'b0;
    for (int t = 1; t <= nOut * 256; t++) begin
      int mode = (((t - 1) / 256) / 3) % 5;
      bit b;
      if ((t % 256) == 1) dens = int'($urandom % 101);
      case (mode)
        0: b = 1'b1;
        1: b = 1'b0;
        2: b = t[0];
        3: b = ((t % 64) < ((t / 256) % 65));
        default: b = (int'($urandom % 100) < dens);
      endcase
      hist[t % 1024] = b;
      bitIn = b;
      if (t == 300) waitPeriod = 12'(waitVal + 5);   // R8: ignored after reset
      @(posedge clk);
      @(negedge clk);
      if ((t % 256) == 0) begin
        expSample = toSample(expY(t));
        if (t / 256 >= 3) begin
          if (waitLeft > 0) waitLeft--;           // R5
          else if (!seeded) begin                 // R6
            seeded = 1; expMin = expSample; expMax = expSample;
          end else begin                          // R7
            if (expSample < expMin) expMin = expSample;
            if (expSample > expMax) expMax = expSample;
          end
        end
      end
      chk("R3 valid", int'(sampleValid), ((t % 256) == 0 && t / 256 >= 3) ? 1 : 0);
      chk("R1/R2/R4 sample", int'($signed(sample)), expSample);
      chk("R5/R6/R7/R8 min", int'($signed(peakMin)), expMin);
      chk("R5/R6/R7/R8 max", int'($signed(peakMax)), expMax);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    doRun(0, 20);    // seeding on the first flagged word; clipping at both ends
    doRun(3, 20);    // short hold-off
    doRun(7, 30);    // longer hold-off, all patterns repeated
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule